// File: doc/BRIEF.md
# ADC Result Accumulator with Snapshot Latch

This block sits behind a sequencer that converts four analog inputs in turn and hands each 12-bit result over as a one-cycle strobe carrying the channel index. While sampling is on, it keeps the newest result of every channel and a 64-bit running total for each channel. It also counts the sample sequences that have completed and the clock cycles that have passed since sampling was switched on. The result range is 0 to 4095 and maps to an input span of 0 V to 1 V.

A host never reads the live registers. It raises a one-cycle snapshot request, and this sets a snapshot bit that clears itself one cycle later. The edge that clears the bit copies every live value into a shadow bank. All reads go through a select code into that shadow bank. A host can therefore read a sum, the sequence count and the cycle count that all belong to the same instant while accumulation carries on.

Top module: `adc_accum_snap`

## Requirements
- R1: After reset every readback code returns zero and the snapshot bit is low.
- R2: While sampling runs, a strobe with channel index c (0 to 3) replaces the latest result of channel c and adds the 12-bit value to the 64-bit total of channel c. Readback codes 0 to 3 give the latest results, zero-extended. Codes 4 to 7 give the totals of channels 0 to 3. Full-scale values accumulate without loss.
- R3: The sequence count increments once each time every channel 0 to 3 has delivered at least one result since the last increment or start. A repeated channel inside a sequence adds nothing extra. Readback code 8 returns this count.
- R4: The cycle count rises by one on every clock edge at which enable is high and was already high on the previous edge. Readback code 9 returns this count.
- R5: On the first edge at which enable is high after being low, or the first such edge after reset, the totals, the sequence count, the cycle count and the partial-sequence record are cleared. A strobe in that cycle is dropped. The latest results are kept.
- R6: While enable is low, strobes are ignored and every live value holds.
- R7: A snapshot request sets the snapshot bit on the next edge. The bit clears on the edge after that. A request that arrives while the bit is set is dropped.
- R8: The edge that clears the snapshot bit copies all live values into the shadow bank. Readback shows only the shadow bank, so its value changes only right after such a copy, whatever sampling does in the meantime.
- R9: Readback codes 10 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Sampling on (1) or off (0) |
| smp_valid_i | input | 1 | Conversion result strobe |
| smp_chan_i | input | 2 | Channel index of the strobed result |
| smp_data_i | input | 12 | Conversion result |
| snap_req_i | input | 1 | Snapshot request |
| snap_bit_o | output | 1 | Self-clearing snapshot bit |
| rd_sel_i | input | 4 | Readback select code |
| rd_data_o | output | 64 | Readback value from the shadow bank |

## Verification
The bench drives several kinds of input:
- A clean four-channel sequence with small values, which pins the totals, the sequence count and the cycle count to hand-computed numbers.
- Round-robin streams, which exercise long accumulation.
- An out-of-order stream with repeated channels, which separates a correct "all channels seen" rule from plain strobe counting.
- A full-scale stream, which shows whether any bits are truncated.

Streams also run while enable is low, which shows whether strobes are ignored, and after enable is raised again, which shows whether the counters clear. Reads are made while a stream runs, both before and after a snapshot, which tells a coherent shadow readback apart from one that leaks live values.

// File: rtl/adc_accum_pkg.sv
package adc_accum_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_RUN   = 2'd2
  } acc_phase_e;

  function automatic acc_phase_e phase_of(logic en, logic en_q);
    if (!en)       return PH_IDLE;
    else if (!en_q) return PH_START;
    else           return PH_RUN;
  endfunction

endpackage

// File: rtl/adc_chan_acc.sv
module adc_chan_acc
  import adc_accum_pkg::*;
#(
  parameter int unsigned CH_ID = 0,
  parameter int unsigned CH_W  = 2,
  parameter int unsigned DW    = 12,
  parameter int unsigned SUM_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_phase_e       phase_i,
  input  logic             smp_valid_i,
  input  logic [CH_W-1:0]  smp_chan_i,
  input  logic [DW-1:0]    smp_data_i,
  output logic [DW-1:0]    last_o,
  output logic [SUM_W-1:0] sum_o,
  output logic             hit_o
);

  assign hit_o = (phase_i == PH_RUN) && smp_valid_i && (smp_chan_i == CH_W'(CH_ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_o <= '0;
      sum_o  <= '0;
    end else if (phase_i == PH_START) begin
      sum_o <= '0;
    end else if (hit_o) begin
      last_o <= smp_data_i;
      sum_o  <= sum_o + SUM_W'(smp_data_i);
    end
  end

endmodule

// File: rtl/adc_seq_track.sv
module adc_seq_track
  import adc_accum_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned SEQ_W = 32,
  parameter int unsigned CYC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_phase_e       phase_i,
  input  logic [N_CH-1:0]  hit_i,
  output logic [SEQ_W-1:0] seq_o,
  output logic [CYC_W-1:0] cyc_o
);

  logic [N_CH-1:0] seen_q;
  logic [N_CH-1:0] seen_d;
  logic            seq_done;

  assign seen_d   = seen_q | hit_i;
  assign seq_done = (|hit_i) && (&seen_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      seq_o  <= '0;
      cyc_o  <= '0;
    end else begin
      unique case (phase_i)
        PH_START: begin
          seen_q <= '0;
          seq_o  <= '0;
          cyc_o  <= '0;
        end
        PH_RUN: begin
          cyc_o <= cyc_o + CYC_W'(1);
          if (seq_done) begin
            seq_o  <= seq_o + SEQ_W'(1);
            seen_q <= '0;
          end else begin
            seen_q <= seen_d;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adc_snap_shadow.sv
module adc_snap_shadow #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned DW    = 12,
  parameter int unsigned SUM_W = 64,
  parameter int unsigned SEQ_W = 32,
  parameter int unsigned CYC_W = 64,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned RD_W  = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       snap_req_i,
  input  logic [N_CH-1:0][DW-1:0]    last_i,
  input  logic [N_CH-1:0][SUM_W-1:0] sum_i,
  input  logic [SEQ_W-1:0]           seq_i,
  input  logic [CYC_W-1:0]           cyc_i,
  input  logic [SEL_W-1:0]           rd_sel_i,
  output logic                       snap_o,
  output logic [RD_W-1:0]            rd_data_o
);

  logic [N_CH-1:0][DW-1:0]    last_sh;
  logic [N_CH-1:0][SUM_W-1:0] sum_sh;
  logic [SEQ_W-1:0]           seq_sh;
  logic [CYC_W-1:0]           cyc_sh;
  logic [RD_W-1:0]            mux_d;

  // bit lives one cycle; requests during that cycle are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_o <= 1'b0;
    else         snap_o <= snap_o ? 1'b0 : snap_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_sh <= '0;
      sum_sh  <= '0;
      seq_sh  <= '0;
      cyc_sh  <= '0;
    end else if (snap_o) begin
      last_sh <= last_i;
      sum_sh  <= sum_i;
      seq_sh  <= seq_i;
      cyc_sh  <= cyc_i;
    end
  end

  always_comb begin
    mux_d = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (rd_sel_i == SEL_W'(i))        mux_d = RD_W'(last_sh[i]);
      if (rd_sel_i == SEL_W'(N_CH + i)) mux_d = RD_W'(sum_sh[i]);
    end
    if (rd_sel_i == SEL_W'(2 * N_CH))     mux_d = RD_W'(seq_sh);
    if (rd_sel_i == SEL_W'(2 * N_CH + 1)) mux_d = RD_W'(cyc_sh);
  end

  assign rd_data_o = mux_d;

endmodule

// File: rtl/adc_accum_snap.sv
module adc_accum_snap
  import adc_accum_pkg::*;
#(
  parameter  int unsigned N_CH  = 4,
  parameter  int unsigned DW    = 12,
  parameter  int unsigned SUM_W = 64,
  parameter  int unsigned SEQ_W = 32,
  parameter  int unsigned CYC_W = 64,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned SEL_W = $clog2(2 * N_CH + 2),
  localparam int unsigned RD_W  = (SUM_W > CYC_W) ? SUM_W : CYC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             smp_valid_i,
  input  logic [CH_W-1:0]  smp_chan_i,
  input  logic [DW-1:0]    smp_data_i,
  input  logic             snap_req_i,
  output logic             snap_bit_o,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [RD_W-1:0]  rd_data_o
);

  logic                       en_q;
  acc_phase_e                 phase;
  logic [N_CH-1:0]            ch_hit;
  logic [N_CH-1:0][DW-1:0]    ch_last;
  logic [N_CH-1:0][SUM_W-1:0] ch_sum;
  logic [SEQ_W-1:0]           seq_cnt;
  logic [CYC_W-1:0]           cyc_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= enable_i;
  end

  assign phase = phase_of(enable_i, en_q);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    adc_chan_acc #(
      .CH_ID(c),
      .CH_W (CH_W),
      .DW   (DW),
      .SUM_W(SUM_W)
    ) u_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .phase_i    (phase),
      .smp_valid_i(smp_valid_i),
      .smp_chan_i (smp_chan_i),
      .smp_data_i (smp_data_i),
      .last_o     (ch_last[c]),
      .sum_o      (ch_sum[c]),
      .hit_o      (ch_hit[c])
    );
  end

  adc_seq_track #(
    .N_CH (N_CH),
    .SEQ_W(SEQ_W),
    .CYC_W(CYC_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase),
    .hit_i  (ch_hit),
    .seq_o  (seq_cnt),
    .cyc_o  (cyc_cnt)
  );

  adc_snap_shadow #(
    .N_CH (N_CH),
    .DW   (DW),
    .SUM_W(SUM_W),
    .SEQ_W(SEQ_W),
    .CYC_W(CYC_W),
    .SEL_W(SEL_W),
    .RD_W (RD_W)
  ) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snap_req_i(snap_req_i),
    .last_i    (ch_last),
    .sum_i     (ch_sum),
    .seq_i     (seq_cnt),
    .cyc_i     (cyc_cnt),
    .rd_sel_i  (rd_sel_i),
    .snap_o    (snap_bit_o),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/adc_accum_chk.sv
module adc_accum_chk #(
  parameter int unsigned SEQ_W = 32,
  parameter int unsigned CYC_W = 64,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned RD_W  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             en_q_i,
  input logic             snap_req_i,
  input logic             snap_bit_i,
  input logic [SEL_W-1:0] rd_sel_i,
  input logic [RD_W-1:0]  rd_data_i,
  input logic [SEQ_W-1:0] seq_i,
  input logic [CYC_W-1:0] cyc_i
);

  p_seq_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && en_q_i) |=> (seq_i == $past(seq_i) || seq_i == $past(seq_i) + SEQ_W'(1)));

  p_cyc_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && en_q_i) |=> (cyc_i == $past(cyc_i) + CYC_W'(1)));

  p_start_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !en_q_i) |=> (cyc_i == '0 && seq_i == '0));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> ($stable(cyc_i) && $stable(seq_i)));

  p_snap_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_req_i && !snap_bit_i) |=> snap_bit_i);

  p_snap_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_bit_i |=> !snap_bit_i);

  p_rd_coherent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_sel_i) && !$past(snap_bit_i)) |-> $stable(rd_data_i));

endmodule

bind adc_accum_snap adc_accum_chk #(
  .SEQ_W(SEQ_W),
  .CYC_W(CYC_W),
  .SEL_W(SEL_W),
  .RD_W (RD_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .en_q_i    (en_q),
  .snap_req_i(snap_req_i),
  .snap_bit_i(snap_bit_o),
  .rd_sel_i  (rd_sel_i),
  .rd_data_i (rd_data_o),
  .seq_i     (seq_cnt),
  .cyc_i     (cyc_cnt)
);

// File: tb/tb_adc_accum_snap.sv
`timescale 1ns/1ps
module tb_adc_accum_snap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [11:0] smp_data = '0;
  logic        snap_req = 1'b0;
  logic        snap_bit;
  logic [3:0]  rd_sel = '0;
  logic [63:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_accum_snap dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .enable_i   (enable),
    .smp_valid_i(smp_valid),
    .smp_chan_i (smp_chan),
    .smp_data_i (smp_data),
    .snap_req_i (snap_req),
    .snap_bit_o (snap_bit),
    .rd_sel_i   (rd_sel),
    .rd_data_o  (rd_data)
  );

  // reference model built from the requirements
  logic [11:0] m_last [4];
  logic [11:0] m_last_sh [4];
  logic [63:0] m_sum [4];
  logic [63:0] m_sum_sh [4];
  logic [31:0] m_seq, m_seq_sh;
  logic [63:0] m_cyc, m_cyc_sh;
  logic [3:0]  m_seen;
  logic        m_enq, m_snap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_last[i] <= '0; m_last_sh[i] <= '0; m_sum[i] <= '0; m_sum_sh[i] <= '0;
      end
      m_seq <= '0; m_seq_sh <= '0; m_cyc <= '0; m_cyc_sh <= '0;
      m_seen <= '0; m_enq <= 1'b0; m_snap <= 1'b0;
    end else begin
      m_enq  <= enable;
      m_snap <= m_snap ? 1'b0 : snap_req;
      if (m_snap) begin
        for (int i = 0; i < 4; i++) begin
          m_last_sh[i] <= m_last[i];
          m_sum_sh[i]  <= m_sum[i];
        end
        m_seq_sh <= m_seq;
        m_cyc_sh <= m_cyc;
      end
      if (enable && !m_enq) begin
        for (int i = 0; i < 4; i++) m_sum[i] <= '0;
        m_seq <= '0; m_cyc <= '0; m_seen <= '0;
      end else if (enable) begin
        m_cyc <= m_cyc + 64'd1;
        if (smp_valid) begin
          m_last[smp_chan] <= smp_data;
          m_sum[smp_chan]  <= m_sum[smp_chan] + 64'(smp_data);
          if ((m_seen | (4'b1 << smp_chan)) == 4'hF) begin
            m_seq  <= m_seq + 32'd1;
            m_seen <= '0;
          end else begin
            m_seen <= m_seen | (4'b1 << smp_chan);
          end
        end
      end
    end
  end

  function automatic logic [63:0] m_rd(int s);
    if (s < 4)  return 64'(m_last_sh[s]);
    if (s < 8)  return m_sum_sh[s-4];
    if (s == 8) return 64'(m_seq_sh);
    if (s == 9) return m_cyc_sh;
    return 64'd0;
  endfunction

  // scoreboard
  typedef struct {
    logic [3:0]  sel;
    logic [63:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (rd_data !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.tag, it.sel, rd_data, it.exp);
      end
    end
  end

  task automatic rd_chk(input int s, input logic [63:0] exp, input string tag);
    @(negedge clk);
    rd_sel = 4'(s);
    sb_q.push_back('{sel: 4'(s), exp: exp, tag: tag});
  endtask

  task automatic read_model(input string tag);
    for (int s = 0; s < 10; s++) rd_chk(s, m_rd(s), tag);
    @(negedge clk);
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic put_smp(input int ch, input int d);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = 2'(ch); smp_data = 12'(d);
  endtask

  task automatic idle_smp();
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic stream(input int mode, input int n);
    int dup_ch [7] = '{2, 2, 0, 1, 3, 3, 1};
    for (int i = 0; i < n; i++) begin
      case (mode)
        1:       put_smp(i % 4, (i * 293 + 17) & 12'hFFF);
        2:       put_smp(i % 4, 12'hFFF);
        default: put_smp(dup_ch[i % 7], i * 5);
      endcase
    end
    idle_smp();
  endtask

  task automatic snapshot();
    @(negedge clk); snap_req = 1'b1;
    @(negedge clk); snap_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_bit(snap_bit, 1'b0, "R1 snap bit after reset");
    for (int s = 0; s < 10; s++) rd_chk(s, 64'd0, "R1 reset readback");
    @(negedge clk);

    // R5 start cycle drops its strobe; R2/R3/R4 directed sequence
    @(negedge clk);
    enable = 1'b1; smp_valid = 1'b1; smp_chan = 2'd0; smp_data = 12'h111;
    put_smp(0, 1); put_smp(1, 2); put_smp(2, 3); put_smp(3, 4);
    idle_smp();
    snapshot();
    rd_chk(0, 64'd1, "R5 start-cycle strobe dropped");
    rd_chk(1, 64'd2, "R2 latest ch1");
    rd_chk(3, 64'd4, "R2 latest ch3");
    rd_chk(4, 64'd1, "R2 sum ch0");
    rd_chk(6, 64'd3, "R2 sum ch2");
    rd_chk(7, 64'd4, "R2 sum ch3");
    rd_chk(8, 64'd1, "R3 one full sequence");
    rd_chk(9, 64'd6, "R4 cycle count");

    // R8 readback unchanged while sampling continues without a snapshot
    fork
      stream(1, 30);
      begin
        rd_chk(4, 64'd1, "R8 shadow sum ch0 held");
        rd_chk(5, 64'd2, "R8 shadow sum ch1 held");
        rd_chk(8, 64'd1, "R8 shadow seq held");
        rd_chk(9, 64'd6, "R8 shadow cyc held");
      end
    join
    snapshot();
    read_model("R2 round robin");

    // R8 snapshot taken mid-stream, read while stream continues
    fork
      stream(1, 40);
      begin
        repeat (5) @(negedge clk);
        snapshot();
        read_model("R8 mid-stream snapshot");
      end
    join

    // R3 out-of-order stream with repeated channels
    stream(3, 21);
    snapshot();
    read_model("R3 duplicates");

    // R2 full-scale accumulation
    stream(2, 80);
    snapshot();
    read_model("R2 full scale");

    // R6 disabled: strobes ignored, values hold
    @(negedge clk); enable = 1'b0;
    stream(1, 12);
    snapshot();
    read_model("R6 disabled");

    // R5 restart clears totals and counts, keeps latest
    @(negedge clk); enable = 1'b1;
    repeat (3) @(negedge clk);
    snapshot();
    rd_chk(4, 64'd0, "R5 sum ch0 cleared");
    rd_chk(7, 64'd0, "R5 sum ch3 cleared");
    rd_chk(8, 64'd0, "R5 seq cleared");
    read_model("R5 restart");

    // R7 held request gives a single-cycle bit
    @(negedge clk); snap_req = 1'b1;
    @(posedge clk); #1 chk_bit(snap_bit, 1'b1, "R7 bit set");
    @(posedge clk); #1 chk_bit(snap_bit, 1'b0, "R7 bit self-clears with request held");
    @(negedge clk); snap_req = 1'b0;
    @(posedge clk); #1 chk_bit(snap_bit, 1'b0, "R7 bit stays low");

    // R9 unused codes
    for (int s = 10; s < 16; s++) rd_chk(s, 64'd0, "R9 unused code");
    repeat (2) @(negedge clk);

    done = 1'b1;
    report();
  end

endmodule